// File: doc/BRIEF.md
# Word-to-Byte Data FIFO Port

This block sits between a 32-bit register bus and a serial engine that moves one byte at a time. A word written to the transmit path is broken into four bytes and queued in a byte-wide transmit FIFO, lowest byte first. A read on the receive path takes up to four bytes from a byte-wide receive FIFO and packs them into one word, the first byte taken landing in the lowest byte lane.

Each bus access is worked off one byte per clock, so an access takes up to four cycles, and the bus is held off through a ready signal while that happens. When the transmit FIFO fills partway through a word, the bytes not yet queued are thrown away and an overflow pulse is raised. When the receive FIFO runs dry partway through a read, the word built so far is returned with the missing lanes at zero and an underflow pulse is raised. Both FIFOs report empty and full flags and a depth counted in whole words, and the flags and transmit depth are also packed into a status word for the register file. Each FIFO can be emptied on its own with a flush input.

Top module: `wbp_data_port`

## Requirements
- R1: After reset, bus_ready is 1, tx_empty and rx_empty are 1, tx_full and rx_full are 0, both word depths are 0 and status_word equals 0x1100_0000.
- R2: A bus write sends its bytes to the transmit FIFO in the order bits 7:0, 15:8, 23:16, 31:24, and the engine receives them in that order on eng_tx_byte.
- R3: A fully accepted bus write clears tx_empty and raises tx_depth_w by one; tx_depth_w is always the number of bytes held divided by four, rounded down.
- R4: When the transmit FIFO is full at a byte step, that byte and all later bytes of the word are dropped, ovf_err pulses high for exactly one cycle, tx_full reads 1 and the bytes already queued are kept.
- R5: A bus read takes up to four bytes from the receive FIFO and returns them on bus_rdata with a one-cycle bus_rvalid, the k-th byte taken placed at bits 8k+7:8k.
- R6: When the receive FIFO is empty at a byte step, the read ends, udf_err pulses for one cycle together with bus_rvalid, the lanes not filled read as zero and rx_empty reads 1.
- R7: rx_full reads 1 when the receive FIFO holds 256 bytes, and a bus read that takes at least one byte clears it.
- R8: A one-cycle tx_flush or rx_flush empties that FIFO: its empty flag reads 1, its full flag 0 and its word depth 0 in the next cycle.
- R9: bus_ready stays low for exactly four cycles after a write or read that completes all four byte steps, and for fewer cycles when the access ends early.
- R10: When bus_wr and bus_rd are both high while bus_ready is 1, only the write is accepted; the read is not performed.
- R11: status_word carries tx_depth_w at bits 7:0, rx_empty at bit 24, rx_full at bit 25, tx_empty at bit 28 and tx_full at bit 29, all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Request to queue bus_wdata as four transmit bytes |
| bus_wdata | input | 32 | Word to transmit |
| bus_rd | input | 1 | Request to assemble one word from the receive FIFO |
| bus_rdata | output | 32 | Assembled receive word |
| bus_rvalid | output | 1 | One-cycle strobe qualifying bus_rdata |
| bus_ready | output | 1 | High when a new bus access can be accepted |
| tx_flush | input | 1 | Empties the transmit FIFO |
| rx_flush | input | 1 | Empties the receive FIFO |
| eng_tx_pop | input | 1 | Engine takes the byte on eng_tx_byte |
| eng_tx_byte | output | 8 | Oldest transmit byte, valid while tx_empty is 0 |
| eng_rx_push | input | 1 | Engine delivers eng_rx_byte to the receive FIFO |
| eng_rx_byte | input | 8 | Received byte |
| tx_empty | output | 1 | Transmit FIFO holds no byte |
| tx_full | output | 1 | Transmit FIFO holds 256 bytes |
| rx_empty | output | 1 | Receive FIFO holds no byte |
| rx_full | output | 1 | Receive FIFO holds 256 bytes |
| tx_depth_w | output | 8 | Transmit bytes held divided by four |
| rx_depth_w | output | 8 | Receive bytes held divided by four |
| status_word | output | 32 | Packed flags and transmit depth |
| ovf_err | output | 1 | One-cycle pulse on a dropped transmit byte |
| udf_err | output | 1 | One-cycle pulse on a short receive word |

## Verification
Transmit words are chosen with distinct values in every lane (0x44332211, 0xA5A55A5A, 0xFFFF0000, 0x000000FF), so a swapped or repeated lane shows up as a wrong byte at the engine. The transmit FIFO is filled to exactly 256 bytes and then offered a word with no room at all and a word with room for one byte, which separates dropping the whole word from keeping the first byte and dropping the rest. Reads are tried with four, eight, two and zero bytes available, telling apart a full assembly, back-to-back words, a partial word with zeroed upper lanes and an empty read; a simultaneous write and read request shows which one wins.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int IDX_W  = $clog2(LANES);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // status_word bit positions decoded by the register file
  localparam int ST_TXD_LSB = 0;
  localparam int ST_TXD_W   = 8;
  localparam int ST_RXE     = 24;
  localparam int ST_RXF     = 25;
  localparam int ST_TXE     = 28;
  localparam int ST_TXF     = 29;
endpackage

// File: rtl/wbp_byte_fifo.sv
module wbp_byte_fifo
  import wbp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  byte_t         push_data,
  input  logic          pop,
  output byte_t         head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  byte_t          mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr, rd_ptr_n;
  logic [CW-1:0]  count_n;
  logic           push_ok, pop_ok, bypass;

  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign rd_ptr_n = rd_ptr + AW'(pop_ok);
  assign count_n  = count + CW'(push_ok) - CW'(pop_ok);
  assign bypass   = push_ok && (wr_ptr == rd_ptr_n);

  // storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // registered read of the next head, with write-through when they collide
  always_ff @(posedge clk) begin
    head <= bypass ? push_data : mem[rd_ptr_n];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
      full   <= (count_n == CW'(DEPTH));
      empty  <= (count_n == '0);
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !full && count == '0));

endmodule

// File: rtl/wbp_tx_split.sv
module wbp_tx_split
  import wbp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  word_t word,
  input  logic  fifo_full,
  output logic  push,
  output byte_t push_byte,
  output logic  busy,
  output logic  ovf
);

  logic [IDX_W-1:0] idx;
  word_t            held;

  assign push      = busy && !fifo_full;
  assign push_byte = held[idx*BYTE_W +: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      held <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        idx  <= '0;
        held <= word;
      end else if (busy) begin
        if (fifo_full) begin
          busy <= 1'b0;
          ovf  <= 1'b1;
        end else if (idx == IDX_W'(LANES - 1)) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  p_ovf_single_r4: assert property (@(posedge clk) disable iff (rst)
    ovf |=> !ovf);
  p_ovf_ends_word_r4: assert property (@(posedge clk) disable iff (rst)
    ovf |-> !busy);

endmodule

// File: rtl/wbp_rx_join.sv
module wbp_rx_join
  import wbp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  fifo_empty,
  input  byte_t head,
  output logic  pop,
  output logic  busy,
  output logic  valid,
  output word_t rdata,
  output logic  udf
);

  logic [IDX_W-1:0] idx;
  word_t            acc, acc_n;

  assign pop   = busy && !fifo_empty;
  assign acc_n = acc | (word_t'(head) << (idx * BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      acc   <= '0;
      valid <= 1'b0;
      rdata <= '0;
      udf   <= 1'b0;
    end else begin
      valid <= 1'b0;
      udf   <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= '0;
      end else if (busy) begin
        if (fifo_empty) begin
          busy  <= 1'b0;
          valid <= 1'b1;
          udf   <= 1'b1;
          rdata <= acc;
        end else if (idx == IDX_W'(LANES - 1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
          rdata <= acc_n;
        end else begin
          acc <= acc_n;
          idx <= idx + 1'b1;
        end
      end
    end
  end

  p_udf_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    udf |-> valid);
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

endmodule

// File: rtl/wbp_data_port.sv
module wbp_data_port
  import wbp_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        bus_ready,
  input  logic        tx_flush,
  input  logic        rx_flush,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_byte,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_byte,
  output logic        tx_empty,
  output logic        tx_full,
  output logic        rx_empty,
  output logic        rx_full,
  output logic [7:0]  tx_depth_w,
  output logic [7:0]  rx_depth_w,
  output logic [31:0] status_word,
  output logic        ovf_err,
  output logic        udf_err
);

  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int RUN_W = $clog2(LANES + 1) + 1;

  logic          tx_busy, rx_busy, start_wr, start_rd;
  logic          tx_push, rx_pop;
  byte_t         tx_push_byte, rx_head;
  logic [CW-1:0] tx_count, rx_count;

  assign bus_ready = !tx_busy && !rx_busy;
  assign start_wr  = bus_wr && bus_ready;
  assign start_rd  = bus_rd && !bus_wr && bus_ready;   // write wins a tie

  wbp_tx_split u_split (
    .clk       (clk),
    .rst       (rst),
    .start     (start_wr),
    .word      (bus_wdata),
    .fifo_full (tx_full),
    .push      (tx_push),
    .push_byte (tx_push_byte),
    .busy      (tx_busy),
    .ovf       (ovf_err)
  );

  wbp_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (tx_flush),
    .push      (tx_push),
    .push_data (tx_push_byte),
    .pop       (eng_tx_pop),
    .head      (eng_tx_byte),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  wbp_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (rx_flush),
    .push      (eng_rx_push),
    .push_data (eng_rx_byte),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  wbp_rx_join u_join (
    .clk        (clk),
    .rst        (rst),
    .start      (start_rd),
    .fifo_empty (rx_empty),
    .head       (rx_head),
    .pop        (rx_pop),
    .busy       (rx_busy),
    .valid      (bus_rvalid),
    .rdata      (bus_rdata),
    .udf        (udf_err)
  );

  assign tx_depth_w = 8'(tx_count >> 2);
  assign rx_depth_w = 8'(rx_count >> 2);

  always_comb begin
    status_word = '0;
    status_word[ST_TXD_LSB +: ST_TXD_W] = tx_depth_w;
    status_word[ST_RXE] = rx_empty;
    status_word[ST_RXF] = rx_full;
    status_word[ST_TXE] = tx_empty;
    status_word[ST_TXF] = tx_full;
  end

  // length of the current stall, for the ready-window check
  logic [RUN_W-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst)            busy_run <= '0;
    else if (bus_ready) busy_run <= '0;
    else                busy_run <= busy_run + 1'b1;
  end

  p_ready_window_r9: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RUN_W'(LANES));
  p_wr_first_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd && bus_ready) |=> (tx_busy && !rx_busy));
  p_rvalid_ready_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> bus_ready);

endmodule

// File: tb/tb_wbp_data_port.sv
module tb_wbp_data_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_ready;
  logic        tx_flush = 1'b0, rx_flush = 1'b0;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0]  eng_tx_byte, eng_rx_byte = '0;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]  tx_depth_w, rx_depth_w;
  logic [31:0] status_word;
  logic        ovf_err, udf_err;

  always #4 clk = ~clk;

  wbp_data_port dut (.*);

  int n_cmp = 0, n_bad = 0;
  int ovf_cnt = 0, udf_cnt = 0, rv_cnt = 0;
  int tx_model = 0;
  logic [7:0]  exp_tx[$];
  logic [7:0]  rx_model[$];
  logic [31:0] exp_rd[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: read words and error pulses
  always @(negedge clk) begin
    if (!rst) begin
      if (ovf_err) ovf_cnt++;
      if (udf_err) udf_cnt++;
      if (bus_rvalid) begin
        rv_cnt++;
        if (exp_rd.size() == 0) chk(0, "R5 unexpected word", bus_rdata, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(bus_rdata == e, "R5/R6 read word", bus_rdata, e);
        end
      end
    end
  end

  // driver: model the write, then issue it; returns stall length
  task automatic bus_write(input logic [31:0] w, output int cyc);
    for (int i = 0; i < 4; i++) begin
      if (tx_model >= 256) break;
      exp_tx.push_back(w[i*8 +: 8]);
      tx_model++;
    end
    while (!bus_ready) @(negedge clk);
    bus_wr = 1'b1; bus_wdata = w;
    @(negedge clk);
    bus_wr = 1'b0;
    cyc = 0;
    while (!bus_ready) begin cyc++; @(negedge clk); end
  endtask

  task automatic bus_read(output int cyc);
    logic [31:0] e;
    e = '0;
    for (int i = 0; i < 4; i++) begin
      if (rx_model.size() == 0) break;
      e[i*8 +: 8] = rx_model.pop_front();
    end
    exp_rd.push_back(e);
    while (!bus_ready) @(negedge clk);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    cyc = 0;
    while (!bus_ready) begin cyc++; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic eng_push(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_byte = b;
    if (rx_model.size() < 256) rx_model.push_back(b);
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_take(input int n);
    for (int i = 0; i < n && !tx_empty; i++) begin
      logic [7:0] e;
      e = exp_tx.size() ? exp_tx.pop_front() : 8'hxx;
      chk(eng_tx_byte == e, "R2 engine byte order", {24'h0, eng_tx_byte}, {24'h0, e});
      eng_tx_pop = 1'b1;
      tx_model--;
      @(negedge clk);
      eng_tx_pop = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc, o0, u0, r0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(bus_ready, "R1 ready", {31'h0, bus_ready}, 32'h1);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 flags",
        {28'h0, tx_empty, rx_empty, tx_full, rx_full}, 32'hC);
    chk(tx_depth_w == 0 && rx_depth_w == 0, "R1 depths", {16'h0, tx_depth_w, rx_depth_w}, 32'h0);
    chk(status_word == 32'h1100_0000, "R1 status", status_word, 32'h1100_0000);

    // R2/R3/R9 single word
    bus_write(32'h4433_2211, cyc);
    chk(cyc == 4, "R9 write stall", cyc, 4);
    @(negedge clk);
    chk(!tx_empty && tx_depth_w == 1, "R3 one word queued", {23'h0, tx_empty, tx_depth_w}, 32'h1);
    tx_take(4);
    chk(tx_empty && tx_depth_w == 0, "R3 drained", {23'h0, tx_empty, tx_depth_w}, 32'h100);

    // R2/R3 several lane patterns
    bus_write(32'hA5A5_5A5A, cyc);
    bus_write(32'hFFFF_0000, cyc);
    bus_write(32'h0000_00FF, cyc);
    @(negedge clk);
    chk(tx_depth_w == 3, "R3 depth three", tx_depth_w, 3);
    tx_take(5);
    chk(tx_depth_w == 1, "R3 depth rounds down", tx_depth_w, 1);
    tx_take(7);

    // R4/R11 fill and overflow
    for (int i = 0; i < 64; i++) bus_write(32'h0101_0101 * (i + 1), cyc);
    @(negedge clk);
    chk(tx_full && tx_depth_w == 64, "R4 full at 256", {23'h0, tx_full, tx_depth_w}, 32'h140);
    chk(status_word == 32'h2100_0040, "R11 status layout", status_word, 32'h2100_0040);
    o0 = ovf_cnt;
    bus_write(32'h1234_5678, cyc);
    @(negedge clk);
    chk(ovf_cnt == o0 + 1, "R4 overflow pulse", ovf_cnt - o0, 1);
    chk(cyc == 1, "R9 early end stall", cyc, 1);
    chk(tx_depth_w == 64 && tx_full, "R4 nothing lost", tx_depth_w, 64);
    tx_take(1);
    chk(!tx_full, "R4 room for one", {31'h0, tx_full}, 0);
    o0 = ovf_cnt;
    bus_write(32'hDDCC_BBAA, cyc);
    @(negedge clk);
    chk(cyc == 2, "R4 partial stall", cyc, 2);
    chk(ovf_cnt == o0 + 1 && tx_full, "R4 mid-word overflow", {30'h0, tx_full, 1'b0} | (ovf_cnt - o0), 3);
    tx_take(256);
    chk(tx_empty && exp_tx.size() == 0, "R4 kept bytes only", exp_tx.size(), 0);

    // R8 flushes
    bus_write(32'h0BAD_F00D, cyc);
    bus_write(32'h0BAD_F00D, cyc);
    tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
    exp_tx.delete(); tx_model = 0;
    chk(tx_empty && !tx_full && tx_depth_w == 0, "R8 tx flush", {23'h0, tx_empty, tx_depth_w}, 32'h100);
    for (int i = 0; i < 6; i++) eng_push(8'(i));
    rx_flush = 1'b1; @(negedge clk); rx_flush = 1'b0;
    rx_model.delete();
    chk(rx_empty && rx_depth_w == 0, "R8 rx flush", {23'h0, rx_empty, rx_depth_w}, 32'h100);

    // R5 full words
    for (int i = 1; i <= 4; i++) eng_push(8'(i));
    @(negedge clk);
    bus_read(cyc);
    chk(cyc == 4, "R9 read stall", cyc, 4);
    chk(rx_empty, "R5 fifo drained", {31'h0, rx_empty}, 1);
    for (int i = 0; i < 8; i++) eng_push(8'(8'hF0 + i));
    bus_read(cyc);
    bus_read(cyc);

    // R6 partial and empty reads
    u0 = udf_cnt;
    eng_push(8'hBE); eng_push(8'hEF);
    bus_read(cyc);
    chk(udf_cnt == u0 + 1 && rx_empty, "R6 partial read", udf_cnt - u0, 1);
    bus_read(cyc);
    chk(udf_cnt == u0 + 2, "R6 empty read", udf_cnt - u0, 2);
    chk(cyc == 1, "R9 empty read stall", cyc, 1);

    // R7 receive full
    for (int i = 0; i < 256; i++) eng_push(8'(i * 3));
    chk(rx_full && rx_depth_w == 64, "R7 rx full", {23'h0, rx_full, rx_depth_w}, 32'h140);
    chk(status_word[25] && !status_word[24], "R11 rx bits", status_word, 32'h1000_0000 | 32'h0200_0000);
    bus_read(cyc);
    chk(!rx_full && rx_depth_w == 63, "R7 full cleared", {23'h0, rx_full, rx_depth_w}, 32'h3F);
    rx_flush = 1'b1; @(negedge clk); rx_flush = 1'b0;
    rx_model.delete();

    // R10 write wins a tie
    eng_push(8'h77);
    r0 = rv_cnt;
    while (!bus_ready) @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 32'hCAFE_0001;
    exp_tx.push_back(8'h01); exp_tx.push_back(8'h00);
    exp_tx.push_back(8'hFE); exp_tx.push_back(8'hCA); tx_model += 4;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    while (!bus_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rv_cnt == r0 && !rx_empty, "R10 read not taken", rv_cnt - r0, 0);
    chk(tx_depth_w == 1, "R10 write taken", tx_depth_w, 1);
    tx_take(4);
    chk(exp_rd.size() == 0, "R5 all words seen", exp_rd.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule